// File: doc/BRIEF.md
# Nibble-Wide Character Display Bus Controller

This block is the host side of a 4-bit parallel link to a character display module. A client hands it one byte at a time over a valid/ready handshake, together with a flag that says whether the byte is an instruction or display data. The controller sends the byte as two strobed nibble writes, upper half first. It then reads the module's status as a pair of nibble reads, and it keeps repeating that read pair until the module reports that it is idle. Only after that does it take the next byte.

The controller drives the register-select line, the read/write line and the enable strobe. It controls the four shared data lines through a separate output value and an output-enable signal, and it reads them through a separate input. The lower four data lines of the module are not connected to this block. Four parameters set the cycle timing of every strobe: the setup before the rise, the high width, the hold after the fall and an idle gap. Each time a status pair completes, the controller reports the 7-bit address counter it read, with a one-cycle valid pulse.

Top module: `lcd_nibble_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `lcd_en`, `lcd_d_oe` and `ac_valid` are 0.
- R2: An accepted byte goes out as two write strobes with `lcd_rw`=0 and `lcd_rs`=`req_rs` (0 = instruction, 1 = data). The first strobe carries byte bits 7:4 on `lcd_d_out` and the second carries bits 3:0.
- R3: A status check starts only after both write strobes of a byte are finished, never between them. It is made of two read strobes with `lcd_rs`=0 and `lcd_rw`=1.
- R4: The busy flag is `lcd_d_in` bit 3 during the first read strobe. If it is 1, the whole read pair is repeated. The second read strobe is always carried out, even when the module is busy.
- R5: `req_ready` is 0 from the cycle after a byte is accepted until a status pair reads not busy. No request is taken while it is 0.
- R6: `lcd_rs` and `lcd_rw` hold their values for at least SETUP_CYC cycles before `lcd_en` rises, and they do not change while it is high. `lcd_en` stays high for exactly PULSE_CYC cycles.
- R7: `lcd_d_oe` is 1 whenever `lcd_en` is high in a write strobe. It is 0 in every cycle in which `lcd_rw` is 1.
- R8: After each status read pair, `ac_valid` pulses for a single cycle. At the same time `ac_value` = {first nibble bits 2:0, second nibble bits 3:0}.
- R9: Between two strobes, `lcd_en` stays low for at least HOLD_CYC+GAP_CYC+SETUP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A byte request is present |
| req_ready | output | 1 | The controller is idle and accepts a request |
| req_rs | input | 1 | 0 = instruction, 1 = display data |
| req_byte | input | 8 | Byte to send |
| lcd_rs | output | 1 | Register select to the module |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe |
| lcd_d_out | output | 4 | Value driven on the upper data lines |
| lcd_d_oe | output | 1 | Output enable for the data lines |
| lcd_d_in | input | 4 | Value sampled from the upper data lines |
| ac_valid | output | 1 | One-cycle pulse: a new address counter value |
| ac_value | output | 7 | Address counter read in the last status pair |

## Verification
Some properties are checked on every cycle by the in-line assertions. These are the bus-direction rule (no drive while reading), the stability of select and direction while the strobe is high, the single-cycle address valid pulse, reads always using instruction select, and the return to a new read pair when busy was seen. Other behaviours can only be shown by the bench scenarios, which run against a module model that can stay busy for a set number of polls. Those are the correct nibble order, the count of status pairs per byte, the value of the assembled address counter including its wrap, the setup and gap timing, and the refusal of a request held during polling.

// File: rtl/lcdn_pkg.sv
package lcdn_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_GAP
    } phase_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WR_HI,
        SQ_WR_LO,
        SQ_RD_HI,
        SQ_RD_LO
    } seq_t;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [3:0] nib;
    } nib_op_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lcdn_strobe.sv
module lcdn_strobe
    import lcdn_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_CYC   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  nib_op_t    op,
    output logic       done,
    output logic [3:0] rd_nib,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [3:0] lcd_d_out,
    output logic       lcd_d_oe,
    input  logic [3:0] lcd_d_in
);
    localparam int MAXC = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, GAP_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    nib_op_t       cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rd_nib <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    cur   <= op;
                    phase <= PH_SETUP;
                    cnt   <= CW'(SETUP_CYC - 1);
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_HIGH;
                    cnt   <= CW'(PULSE_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_HIGH: if (cnt == '0) begin
                    if (cur.rw) rd_nib <= lcd_d_in;
                    phase <= PH_HOLD;
                    cnt   <= CW'(HOLD_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) begin
                    phase <= PH_GAP;
                    cnt   <= CW'(GAP_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_GAP: if (cnt == '0) phase <= PH_IDLE;
                        else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign done      = (phase == PH_GAP) && (cnt == '0);
    assign lcd_rs    = cur.rs;
    assign lcd_rw    = cur.rw;
    assign lcd_en    = (phase == PH_HIGH);
    assign lcd_d_out = cur.nib;
    assign lcd_d_oe  = !cur.rw && (phase == PH_SETUP || phase == PH_HIGH || phase == PH_HOLD);

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        lcd_rw |-> !lcd_d_oe);                                               // R7
    AST_CTRL_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_rs) && $stable(lcd_rw))); // R6
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> (phase == PH_IDLE));                                       // R3

endmodule

// File: rtl/lcdn_seq.sv
module lcdn_seq
    import lcdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [7:0] req_byte,
    input  logic       eng_done,
    input  logic [3:0] rd_nib,
    output logic       start,
    output nib_op_t    op,
    output logic       ac_valid,
    output logic [6:0] ac_value
);
    seq_t       state;
    logic       go;
    logic [7:0] byte_q;
    logic       rs_q;
    logic       busy_q;
    logic [2:0] ac_hi_q;

    assign req_ready = (state == SQ_IDLE);
    assign start     = go;

    always_comb begin
        case (state)
            SQ_WR_HI: op = '{rs: rs_q, rw: 1'b0, nib: byte_q[7:4]};
            SQ_WR_LO: op = '{rs: rs_q, rw: 1'b0, nib: byte_q[3:0]};
            SQ_RD_HI,
            SQ_RD_LO: op = '{rs: 1'b0, rw: 1'b1, nib: 4'h0};
            default:  op = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            go       <= 1'b0;
            byte_q   <= '0;
            rs_q     <= 1'b0;
            busy_q   <= 1'b0;
            ac_hi_q  <= '0;
            ac_valid <= 1'b0;
            ac_value <= '0;
        end else begin
            ac_valid <= 1'b0;
            if (go) go <= 1'b0;
            case (state)
                SQ_IDLE: if (req_valid) begin
                    byte_q <= req_byte;
                    rs_q   <= req_rs;
                    state  <= SQ_WR_HI;
                    go     <= 1'b1;
                end
                SQ_WR_HI: if (eng_done) begin
                    state <= SQ_WR_LO;
                    go    <= 1'b1;
                end
                SQ_WR_LO: if (eng_done) begin
                    state <= SQ_RD_HI;
                    go    <= 1'b1;
                end
                SQ_RD_HI: if (eng_done) begin
                    busy_q  <= rd_nib[3];
                    ac_hi_q <= rd_nib[2:0];
                    state   <= SQ_RD_LO;
                    go      <= 1'b1;
                end
                SQ_RD_LO: if (eng_done) begin
                    ac_valid <= 1'b1;
                    ac_value <= {ac_hi_q, rd_nib};
                    if (busy_q) begin
                        state <= SQ_RD_HI;
                        go    <= 1'b1;
                    end else begin
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_AC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ac_valid |=> !ac_valid);                                             // R8
    AST_READ_USES_CMD_SEL: assert property (@(posedge clk) disable iff (rst)
        (start && op.rw) |-> !op.rs);                                        // R3
    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_ready && state == SQ_WR_HI));     // R5
    AST_BUSY_REPOLL: assert property (@(posedge clk) disable iff (rst)
        (eng_done && state == SQ_RD_LO && busy_q) |=> (state == SQ_RD_HI));  // R4

endmodule

// File: rtl/lcd_nibble_ctrl.sv
module lcd_nibble_ctrl
    import lcdn_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int GAP_CYC   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [7:0] req_byte,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en,
    output logic [3:0] lcd_d_out,
    output logic       lcd_d_oe,
    input  logic [3:0] lcd_d_in,
    output logic       ac_valid,
    output logic [6:0] ac_value
);
    logic       start;
    logic       eng_done;
    logic [3:0] rd_nib;
    nib_op_t    op;

    lcdn_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_rs    (req_rs),
        .req_byte  (req_byte),
        .eng_done  (eng_done),
        .rd_nib    (rd_nib),
        .start     (start),
        .op        (op),
        .ac_valid  (ac_valid),
        .ac_value  (ac_value)
    );

    lcdn_strobe #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (op),
        .done      (eng_done),
        .rd_nib    (rd_nib),
        .lcd_rs    (lcd_rs),
        .lcd_rw    (lcd_rw),
        .lcd_en    (lcd_en),
        .lcd_d_out (lcd_d_out),
        .lcd_d_oe  (lcd_d_oe),
        .lcd_d_in  (lcd_d_in)
    );

endmodule

// File: tb/tb_lcd_nibble_ctrl.sv
`timescale 1ns/1ps
module tb_lcd_nibble_ctrl;
    localparam int SETUP_CYC = 2;
    localparam int PULSE_CYC = 4;
    localparam int HOLD_CYC  = 2;
    localparam int GAP_CYC   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_rs = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic       lcd_rs, lcd_rw, lcd_en, lcd_d_oe;
    logic [3:0] lcd_d_out, lcd_d_in;
    logic       ac_valid;
    logic [6:0] ac_value;

    always #2.5 clk = ~clk;

    lcd_nibble_ctrl #(
        .SETUP_CYC (SETUP_CYC), .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),  .GAP_CYC   (GAP_CYC)
    ) dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
        .req_rs (req_rs), .req_byte (req_byte), .lcd_rs (lcd_rs), .lcd_rw (lcd_rw),
        .lcd_en (lcd_en), .lcd_d_out (lcd_d_out), .lcd_d_oe (lcd_d_oe),
        .lcd_d_in (lcd_d_in), .ac_valid (ac_valid), .ac_value (ac_value)
    );

    int checks = 0;
    int errors = 0;

    // display module model
    int         busy_preset = 0;
    int         busy_left = 0;
    logic [6:0] ac_model = 7'h00;
    logic       rd_phase = 1'b0;
    logic       busy_at = 1'b0;
    logic       wr_half = 1'b0;
    logic [3:0] hi_nib = 4'h0;
    logic [3:0] first_nib = 4'h0;
    logic [7:0] got_byte = 8'h00;
    logic       got_rs = 1'b0;
    int         bytes_n = 0, pairs = 0, acv_n = 0;
    logic [6:0] last_ac = 7'h00;
    int         seq_err = 0, tim_err = 0, oe_err = 0;

    // monitor state
    logic prev_en = 1'b0, prev_rs = 1'b0, prev_rw = 1'b0, seen_pulse = 1'b0;
    int   ctl_stable = 0, high_cnt = 0, low_cnt = 0;

    assign lcd_d_in = (lcd_en && lcd_rw) ?
                      (rd_phase ? ac_model[3:0] : {busy_left != 0, ac_model[6:4]}) : 4'h0;

    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_rw && lcd_d_oe) oe_err++;
            if (lcd_en && !lcd_rw && !lcd_d_oe) oe_err++;
            if (ac_valid) begin
                acv_n++;
                last_ac = ac_value;
            end
            if (lcd_en && !prev_en) begin
                if (ctl_stable < SETUP_CYC || lcd_rs != prev_rs || lcd_rw != prev_rw) tim_err++;
                if (seen_pulse && low_cnt < HOLD_CYC + GAP_CYC + SETUP_CYC) tim_err++;
                high_cnt = 1;
                seen_pulse = 1'b1;
            end else if (lcd_en && prev_en) begin
                high_cnt++;
                if (lcd_rs != prev_rs || lcd_rw != prev_rw) tim_err++;
            end else if (!lcd_en && prev_en) begin
                if (high_cnt != PULSE_CYC) tim_err++;
                low_cnt = 1;
                if (!lcd_rw) begin
                    if (rd_phase) seq_err++;
                    if (!wr_half) begin
                        hi_nib = lcd_d_out;
                        got_rs = lcd_rs;
                        wr_half = 1'b1;
                    end else begin
                        got_byte = {hi_nib, lcd_d_out};
                        first_nib = hi_nib;
                        if (lcd_rs != got_rs) seq_err++;
                        bytes_n++;
                        wr_half = 1'b0;
                        busy_left = busy_preset;
                        ac_model = ac_model + 7'd1;
                    end
                end else begin
                    if (lcd_rs || wr_half) seq_err++;
                    if (!rd_phase) begin
                        rd_phase = 1'b1;
                        busy_at = (busy_left != 0);
                    end else begin
                        rd_phase = 1'b0;
                        pairs++;
                        if (busy_at) busy_left--;
                    end
                end
            end else begin
                low_cnt++;
            end
            if (lcd_rs != prev_rs || lcd_rw != prev_rw) ctl_stable = 1;
            else ctl_stable++;
            prev_en = lcd_en;
            prev_rs = lcd_rs;
            prev_rw = lcd_rw;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        chk(lcd_en == 1'b0, "R1 lcd_en after reset", int'(lcd_en), 0);
        chk(lcd_d_oe == 1'b0, "R1 lcd_d_oe after reset", int'(lcd_d_oe), 0);
        chk(ac_valid == 1'b0, "R1 ac_valid after reset", int'(ac_valid), 0);
    endtask

    task automatic t_send(input logic rs, input logic [7:0] b, input int nbusy,
                          input logic [6:0] ac_start);
        int b0, p0, a0, n;
        @(negedge clk);
        busy_preset = nbusy;
        ac_model = ac_start;
        b0 = bytes_n; p0 = pairs; a0 = acv_n;
        req_valid = 1'b1; req_rs = rs; req_byte = b;
        n = 0;
        while (!req_ready && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        req_byte = ~b;
        req_rs = ~rs;
        chk(req_ready == 1'b0, "R5 ready low after accept", int'(req_ready), 0);
        n = 0;
        while (!req_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n < 5000, "R5 ready returns", n, 5000);
        @(negedge clk);
        @(negedge clk);
        chk(bytes_n - b0 == 1, "R5 exactly one byte sent", bytes_n - b0, 1);
        chk(got_byte == b, "R2 byte on bus", int'(got_byte), int'(b));
        chk(first_nib == b[7:4], "R2 high nibble first", int'(first_nib), int'(b[7:4]));
        chk(got_rs == rs, "R2 select value", int'(got_rs), int'(rs));
        chk(pairs - p0 == nbusy + 1, "R4 status pairs", pairs - p0, nbusy + 1);
        chk(seq_err == 0, "R3 read placement and select", seq_err, 0);
        chk(acv_n - a0 == nbusy + 1, "R8 ac_valid pulses", acv_n - a0, nbusy + 1);
        chk(last_ac == ac_start + 7'd1, "R8 address value", int'(last_ac), int'(ac_start + 7'd1));
        chk(tim_err == 0, "R6 R9 strobe timing", tim_err, 0);
        chk(oe_err == 0, "R7 bus direction", oe_err, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_send(1'b0, 8'h28, 0, 7'h00);
        t_send(1'b1, 8'hA5, 2, 7'h10);
        t_send(1'b1, 8'h0F, 5, 7'h7F);
        t_send(1'b0, 8'hF0, 1, 7'h3C);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule